// File: doc/BRIEF.md
# Cache ECC Error Trap Controller

This block sits beside a cache and its system-bus interface and converts classified error events into processor trap requests. Each event arrives as a one-cycle strobe that carries an error class and the operation that was under way when the error was seen. From these two fields the block picks at most one of four trap outputs and gates it with a software-programmed enable bit. The four traps are a fast ECC trap, an instruction access error, a data access error and a disrupting ECC error.

Every recognised event also sets a sticky status bit, whether or not its trap is enabled. Software clears status bits by writing ones to them. The same configuration register that holds the three enable bits also carries force-check-bit controls for the tag and data arrays, which the block drives straight to the cache datapath.

Top module: `cache_err_trap`

## Requirements
- R1: While reset is asserted and after it is released, every trap output is 0, every force output is 0, and the enable register and the status register both read as 0.
- R2: A write with cfgAddr=0 loads the enable register. Bits 18:3 and 1:0 are stored. Bit 2 and bits 63:19 are not stored and always read back as 0. With cfgAddr=0, cfgRdata shows the enable register.
- R3: forceTagEn follows enable bit 18, forceTagVal follows bits 17:14, forceDataEn follows bit 13 and forceDataVal follows bits 12:4.
- R4: Event classes are 0 corrected, 1 uncorrectable, 2 bus fault and 3 reserved. Operations are 0 load, 1 instruction fetch, 2 atomic, 3 store merge, 4 writeback, 5 copyout, and 6 and 7 reserved. A class 0 or 1 event on operation 0, 1 or 2, with enable bit 3 set, makes trapFast 1 in the cycle after the strobe.
- R5: An event on operation 3, 4 or 5 never raises trapFast, whatever its class.
- R6: With enable bit 1 set, a class 2 event raises trapInst when its operation is 1, and raises trapData when its operation is 0 or 2. Both traps appear in the cycle after the strobe.
- R7: With enable bit 1 set, a class 1 or class 2 event on operation 3, 4 or 5 raises trapDisr in the cycle after the strobe.
- R8: With enable bit 0 set, a class 0 event on operation 3, 4 or 5 raises trapDisr in the cycle after the strobe.
- R9: Each recognised event sets one status bit, whether or not its trap is enabled. The bits are: 0 corrected on operations 0-2, 1 uncorrectable on operations 0-2, 2 corrected on operations 3-5, 3 uncorrectable on operations 3-5, 4 bus fault on operation 1, 5 bus fault on operations 0 or 2, and 6 bus fault on operations 3-5. With cfgAddr=1, cfgRdata shows these bits in 6:0, with zeros above.
- R10: A write with cfgAddr=1 clears each status bit whose data bit is 1 and leaves the others set. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R11: An event with class 3, or with operation 6 or 7, raises no trap and sets no status bit.
- R12: A trap output is 1 only in the cycle that follows a strobed event. In any cycle after evValid was low, all four trap outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Error event strobe |
| evClass | input | 2 | Error class of the event |
| evOp | input | 3 | Operation that caused the event |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 enable, 1 status |
| cfgWdata | input | 64 | Register write data |
| cfgRdata | output | 64 | Read data of the selected register |
| forceTagEn | output | 1 | Force tag check bits |
| forceTagVal | output | 4 | Forced tag check value |
| forceDataEn | output | 1 | Force data check bits |
| forceDataVal | output | 9 | Forced data check value |
| trapFast | output | 1 | Fast ECC trap pulse |
| trapInst | output | 1 | Instruction access error trap pulse |
| trapData | output | 1 | Data access error trap pulse |
| trapDisr | output | 1 | Disrupting ECC error trap pulse |

## Verification
The hardest state to reach from the ports is a status write that clears a bit in the very cycle an event sets it. Reaching it takes a register write and an event strobe lined up on the same edge. The bench drives exactly that pairing, then a clear alone and a partial clear, and reads the status back each time. It also sweeps every class and operation pair twice, once with all enables set and once with all clear, to show that logging does not depend on the enables. A long random phase then mixes enable writes with events, so that an enable change and an event often fall on the same cycle.

// File: rtl/cache_err_trap_pkg.sv
package cache_err_trap_pkg;

  typedef enum logic [1:0] {
    CLS_CORR = 2'd0,
    CLS_UNCORR = 2'd1,
    CLS_BUS = 2'd2,
    CLS_RSV = 2'd3
  } errClass_e;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_IFETCH = 3'd1,
    OP_ATOMIC = 3'd2,
    OP_MERGE = 3'd3,
    OP_WBACK = 3'd4,
    OP_COPYOUT = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } errOp_e;

  // status bit positions
  localparam int ST_CORR_RD = 0;
  localparam int ST_UNC_RD = 1;
  localparam int ST_CORR_BG = 2;
  localparam int ST_UNC_BG = 3;
  localparam int ST_BUS_IF = 4;
  localparam int ST_BUS_LD = 5;
  localparam int ST_BUS_BG = 6;
  localparam int ST_W = 7;

  // enable register field positions
  localparam int EN_CORR = 0;
  localparam int EN_NONCORR = 1;
  localparam int EN_FAST = 3;
  localparam int FD_LO = 4;
  localparam int FD_HI = 12;
  localparam int FD_EN = 13;
  localparam int FT_LO = 14;
  localparam int FT_HI = 17;
  localparam int FT_EN = 18;
  localparam int EN_USED = 19;

  typedef struct packed {
    logic [ST_W-1:0] logSet;
    logic reqFast;
    logic reqInst;
    logic reqData;
    logic reqDisrCorr;
    logic reqDisrNc;
    logic enWr;
    logic stClr;
  } ctrlStrb_t;

endpackage

// File: rtl/cache_err_trap_ctrl.sv
module cache_err_trap_ctrl
  import cache_err_trap_pkg::*;
(
  input  logic      evValid,
  input  logic [1:0] evClass,
  input  logic [2:0] evOp,
  input  logic      cfgWe,
  input  logic      cfgAddr,
  output ctrlStrb_t strb
);

  errClass_e cls;
  errOp_e op;
  logic localRd;
  logic bgOp;
  logic goodEv;
  logic isCorr;
  logic isUnc;
  logic isBus;

  assign cls = errClass_e'(evClass);
  assign op = errOp_e'(evOp);

  always_comb begin
    localRd = 1'b0;
    bgOp = 1'b0;
    unique case (op)
      OP_LOAD, OP_IFETCH, OP_ATOMIC: localRd = 1'b1;
      OP_MERGE, OP_WBACK, OP_COPYOUT: bgOp = 1'b1;
      default: ;
    endcase
  end

  assign goodEv = evValid && (cls != CLS_RSV) && (localRd || bgOp);
  assign isCorr = goodEv && (cls == CLS_CORR);
  assign isUnc = goodEv && (cls == CLS_UNCORR);
  assign isBus = goodEv && (cls == CLS_BUS);

  always_comb begin
    strb = '0;
    strb.logSet[ST_CORR_RD] = isCorr && localRd;
    strb.logSet[ST_UNC_RD] = isUnc && localRd;
    strb.logSet[ST_CORR_BG] = isCorr && bgOp;
    strb.logSet[ST_UNC_BG] = isUnc && bgOp;
    strb.logSet[ST_BUS_IF] = isBus && (op == OP_IFETCH);
    strb.logSet[ST_BUS_LD] = isBus && ((op == OP_LOAD) || (op == OP_ATOMIC));
    strb.logSet[ST_BUS_BG] = isBus && bgOp;
    strb.reqFast = strb.logSet[ST_CORR_RD] || strb.logSet[ST_UNC_RD];
    strb.reqInst = strb.logSet[ST_BUS_IF];
    strb.reqData = strb.logSet[ST_BUS_LD];
    strb.reqDisrCorr = strb.logSet[ST_CORR_BG];
    strb.reqDisrNc = strb.logSet[ST_UNC_BG] || strb.logSet[ST_BUS_BG];
    strb.enWr = cfgWe && !cfgAddr;
    strb.stClr = cfgWe && cfgAddr;
  end

endmodule

// File: rtl/cache_err_trap_dpath.sv
module cache_err_trap_dpath
  import cache_err_trap_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             cfgAddr,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  output logic [REG_W-1:0] enQ,
  output logic [ST_W-1:0]  statusQ,
  output logic             trapFast,
  output logic             trapInst,
  output logic             trapData,
  output logic             trapDisr
);

  localparam logic [EN_USED-1:0] USED_MASK = ~(EN_USED'(1) << 2);
  localparam logic [REG_W-1:0] WR_MASK = REG_W'(USED_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (strb.enWr) begin
      enQ <= cfgWdata & WR_MASK;
    end
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_status
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[i] <= 1'b0;
      end else begin
        statusQ[i] <= strb.logSet[i] || (statusQ[i] && !(strb.stClr && cfgWdata[i]));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapFast <= 1'b0;
      trapInst <= 1'b0;
      trapData <= 1'b0;
      trapDisr <= 1'b0;
    end else begin
      trapFast <= strb.reqFast && enQ[EN_FAST];
      trapInst <= strb.reqInst && enQ[EN_NONCORR];
      trapData <= strb.reqData && enQ[EN_NONCORR];
      trapDisr <= (strb.reqDisrCorr && enQ[EN_CORR]) || (strb.reqDisrNc && enQ[EN_NONCORR]);
    end
  end

  assign cfgRdata = cfgAddr ? REG_W'(statusQ) : enQ;

endmodule

// File: rtl/cache_err_trap.sv
module cache_err_trap
  import cache_err_trap_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [1:0]       evClass,
  input  logic [2:0]       evOp,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  output logic             forceTagEn,
  output logic [3:0]       forceTagVal,
  output logic             forceDataEn,
  output logic [8:0]       forceDataVal,
  output logic             trapFast,
  output logic             trapInst,
  output logic             trapData,
  output logic             trapDisr
);

  ctrlStrb_t strb;
  logic [REG_W-1:0] enQ;
  logic [ST_W-1:0] statusQ;

  cache_err_trap_ctrl u_ctrl (
    .evValid(evValid),
    .evClass(evClass),
    .evOp(evOp),
    .cfgWe(cfgWe),
    .cfgAddr(cfgAddr),
    .strb(strb)
  );

  cache_err_trap_dpath #(.REG_W(REG_W)) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata),
    .enQ(enQ),
    .statusQ(statusQ),
    .trapFast(trapFast),
    .trapInst(trapInst),
    .trapData(trapData),
    .trapDisr(trapDisr)
  );

  assign forceTagEn = enQ[FT_EN];
  assign forceTagVal = enQ[FT_HI:FT_LO];
  assign forceDataEn = enQ[FD_EN];
  assign forceDataVal = enQ[FD_HI:FD_LO];

endmodule

// File: rtl/cache_err_trap_chk.sv
module cache_err_trap_chk
  import cache_err_trap_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            evValid,
  input logic [1:0]      evClass,
  input logic [2:0]      evOp,
  input logic            cfgWe,
  input logic            enNc,
  input logic            enFast,
  input logic [ST_W-1:0] statusQ,
  input logic            trapFast,
  input logic            trapInst,
  input logic            trapData,
  input logic            trapDisr
);

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!trapFast && !trapInst && !trapData && !trapDisr);
    end
  end

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |=> !(trapFast || trapInst || trapData || trapDisr));

  // R5
  bg_no_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evOp >= 3'd3 && evOp <= 3'd5) |=> !trapFast);

  // R11
  rsv_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !cfgWe && (evClass == 2'd3 || evOp >= 3'd6))
      |=> (!(trapFast || trapInst || trapData || trapDisr) && statusQ == $past(statusQ)));

  // R4
  fast_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evClass <= 2'd1 && evOp <= 3'd2 && enFast) |=> trapFast);

  // R6
  ifetch_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evClass == 2'd2 && evOp == 3'd1 && enNc) |=> (trapInst && !trapData));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evClass == 2'd0 && evOp == 3'd0) |=> statusQ[ST_CORR_RD]);

endmodule

bind cache_err_trap cache_err_trap_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .evValid(evValid),
  .evClass(evClass),
  .evOp(evOp),
  .cfgWe(cfgWe),
  .enNc(enQ[1]),
  .enFast(enQ[3]),
  .statusQ(statusQ),
  .trapFast(trapFast),
  .trapInst(trapInst),
  .trapData(trapData),
  .trapDisr(trapDisr)
);

// File: tb/sim_cache_err_trap.sv
`timescale 1ns/1ps
module sim_cache_err_trap;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0;
  logic [1:0] evClass = '0;
  logic [2:0] evOp = '0;
  logic cfgWe = 1'b0;
  logic cfgAddr = 1'b0;
  logic [63:0] cfgWdata = '0;
  logic [63:0] cfgRdata;
  logic forceTagEn, forceDataEn;
  logic [3:0] forceTagVal;
  logic [8:0] forceDataVal;
  logic trapFast, trapInst, trapData, trapDisr;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cache_err_trap u0 (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evClass(evClass), .evOp(evOp),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .forceTagEn(forceTagEn), .forceTagVal(forceTagVal),
    .forceDataEn(forceDataEn), .forceDataVal(forceDataVal),
    .trapFast(trapFast), .trapInst(trapInst), .trapData(trapData), .trapDisr(trapDisr)
  );

  // behavioural reference model
  logic [63:0] mEn = '0;
  logic [6:0] mSt = '0;
  logic mF = 0, mI = 0, mD = 0, mZ = 0;

  always @(posedge clk) begin
    logic [6:0] s;
    logic [6:0] clr;
    logic nf, ni, nd, nz, bg;
    if (!rstN) begin
      mEn = '0; mSt = '0; mF = 0; mI = 0; mD = 0; mZ = 0;
    end else begin
      s = '0; nf = 0; ni = 0; nd = 0; nz = 0;
      bg = (evOp >= 3);
      if (evValid && evClass != 3 && evOp < 6) begin
        case (evClass)
          2'd0: if (bg) begin s[2] = 1; nz = mEn[0]; end else begin s[0] = 1; nf = mEn[3]; end
          2'd1: if (bg) begin s[3] = 1; nz = mEn[1]; end else begin s[1] = 1; nf = mEn[3]; end
          default: if (evOp == 1) begin s[4] = 1; ni = mEn[1]; end
                   else if (bg) begin s[6] = 1; nz = mEn[1]; end
                   else begin s[5] = 1; nd = mEn[1]; end
        endcase
      end
      clr = (cfgWe && cfgAddr) ? cfgWdata[6:0] : 7'd0;
      mSt = (mSt & ~clr) | s;
      if (cfgWe && !cfgAddr) mEn = cfgWdata & 64'h7FFFB;
      mF = nf; mI = ni; mD = nd; mZ = nz;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R4 trapFast", 64'(trapFast), 64'(mF));
      chk("R6 trapInst", 64'(trapInst), 64'(mI));
      chk("R6 trapData", 64'(trapData), 64'(mD));
      chk("R7 trapDisr", 64'(trapDisr), 64'(mZ));
      chk("R3 force", {45'd0, forceTagEn, forceTagVal, forceDataEn, forceDataVal, 4'd0},
          {45'd0, mEn[18:4], 4'd0});
      if (cfgAddr) chk("R9 status read", cfgRdata, {57'd0, mSt});
      else chk("R2 enable read", cfgRdata, mEn);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wrReg(input logic addr, input logic [63:0] d);
    cfgWe = 1; cfgAddr = addr; cfgWdata = d;
    tick();
    cfgWe = 0;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic anyTrap;
    // R1 reset state
    tick(); tick();
    chk("R1 traps", {60'd0, trapFast, trapInst, trapData, trapDisr}, 64'd0);
    chk("R1 forces", {49'd0, forceTagEn, forceTagVal, forceDataEn, forceDataVal}, 64'd0);
    chk("R1 enable", cfgRdata, 64'd0);
    cfgAddr = 1; #1;
    chk("R1 status", cfgRdata, 64'd0);
    cfgAddr = 0;
    rstN = 1;
    tick();

    // R2 reserved bits
    wrReg(0, '1);
    chk("R2 reserved zero", cfgRdata, 64'h7FFFB);
    chk("R3 all forces", {49'd0, forceTagEn, forceTagVal, forceDataEn, forceDataVal},
        {49'd0, 1'b1, 4'hF, 1'b1, 9'h1FF});
    wrReg(0, (64'd1 << 18) | (64'hA << 14) | (64'h15A << 4) | 64'h5);
    chk("R3 field split", {49'd0, forceTagEn, forceTagVal, forceDataEn, forceDataVal},
        {49'd0, 1'b1, 4'hA, 1'b0, 9'h15A});
    chk("R2 pattern", cfgRdata, (64'd1 << 18) | (64'hA << 14) | (64'h15A << 4) | 64'h1);

    // sweep of every class and operation, enables on then off
    for (int pass = 0; pass < 2; pass++) begin
      wrReg(0, pass == 0 ? 64'hB : 64'h0);
      for (int c = 0; c < 4; c++) begin
        for (int o = 0; o < 8; o++) begin
          cfgAddr = 1; evValid = 1; evClass = 2'(c); evOp = 3'(o);
          tick();
          evValid = 0;
          anyTrap = trapFast | trapInst | trapData | trapDisr;
          if (c == 3 || o >= 6) begin
            chk("R11 no trap", 64'(anyTrap), 64'd0);
            chk("R11 no status", cfgRdata, 64'd0);
          end else begin
            chk("R9 logged", 64'(cfgRdata != 0), 64'd1);
            if (pass == 1) chk("R9 no trap when disabled", 64'(anyTrap), 64'd0);
            if (o >= 3) chk("R5 no fast on background op", 64'(trapFast), 64'd0);
            if (pass == 0 && c == 0 && o >= 3) chk("R8 corrected background", 64'(trapDisr), 64'd1);
            if (pass == 0 && c == 2 && o == 1) chk("R6 ifetch bus", 64'(trapInst), 64'd1);
          end
          tick();
          chk("R12 single pulse", {60'd0, trapFast, trapInst, trapData, trapDisr}, 64'd0);
          wrReg(1, '1);
        end
      end
    end

    // R10 set versus clear collision
    cfgAddr = 1;
    evValid = 1; evClass = 0; evOp = 0;
    tick();
    cfgWe = 1; cfgWdata = 64'h1;
    tick();
    evValid = 0; cfgWe = 0;
    chk("R10 set wins", cfgRdata, 64'h1);
    wrReg(1, 64'h1);
    chk("R10 clear", cfgRdata, 64'h0);
    evValid = 1; evClass = 2; evOp = 5;
    tick();
    evClass = 1; evOp = 2;
    tick();
    evValid = 0;
    chk("R9 two bits", cfgRdata, 64'h42);
    wrReg(1, 64'h40);
    chk("R10 partial clear", cfgRdata, 64'h02);

    // random mix, checked by the model
    for (int k = 0; k < 2000; k++) begin
      evValid = 1'($urandom);
      evClass = 2'($urandom);
      evOp = 3'($urandom);
      cfgAddr = 1'($urandom);
      cfgWe = (($urandom % 6) == 0);
      cfgWdata = {$urandom, $urandom};
      tick();
    end
    evValid = 0; cfgWe = 0;
    tick(); tick();
    finishRun();
  end

endmodule